// File: doc/BRIEF.md
# Sliding-Window Address Sequencer (one dimension)

This block produces one dimension of a data-driven memory address sequence. Three registers are held by three copies of one signed stepper cell: a sweep origin, a sweep bound and the current address. The address starts at the origin and moves by a programmable signed step on each step request. It continues until it reaches the bound, until a programmed number of addresses has been produced, or until an escape request arrives. Each of these events ends the sweep.

When a sweep ends, the origin and the bound each move by their own signed delta in the same clock edge, and the address restarts from the new origin. Plain raster, rotated, sheared and non-rectangular scan orders therefore differ only in the programmed steps. The whole scan finishes when the new origin has moved past a programmed outer bound. The unit then stays done until it is configured again.

A controller with three states (IDLE, SWEEP, DONE) sequences the unit. The transitions are:
- LOAD: from any state to SWEEP, on `cfg_load`.
- NEXT_SWEEP: SWEEP to SWEEP, on an end of sweep that is not final.
- FINISH: SWEEP to DONE, on the final end of sweep.

All other conditions hold the current state.

Top module: `slide_addr_unit`

## Requirements
- R1: After reset, `addr` is 0, `addr_valid`, `scan_done` and `sweep_end` are 0, and `end_cause` is 2'b00 (none).
- R2: A `cfg_load` captures all configuration inputs and takes precedence over `step_req` and `escape_req` in the same cycle. At the next edge, `addr` equals `cfg_base`, `addr_valid` is 1, `scan_done` and `sweep_end` are 0, and `end_cause` is 2'b00.
- R3: In SWEEP, a step request that does not end the sweep adds the signed address step to `addr` (16-bit two's-complement wrap).
- R4: In SWEEP, a step request while `addr` equals the current bound ends the sweep with `end_cause` 2'b10.
- R5: The step request that would produce address number max+1 of a sweep ends that sweep with `end_cause` 2'b11, so a sweep produces at most `cfg_max_steps` addresses. A maximum of 0 disables the count limit.
- R6: In SWEEP, `escape_req` ends the sweep at once, with or without a step request, with `end_cause` 2'b01. When several causes hold in one cycle, the priority is escape, then bound, then count.
- R7: At an end of sweep, the origin moves by the origin delta and the bound moves by the bound delta. `addr` restarts at the new origin, and `sweep_end` is 1 for exactly the one cycle after the ending request.
- R8: If the new origin is past the outer bound, the scan finishes. "Past" means greater when the origin delta is zero or positive, and less when it is negative. In the next cycle `scan_done` is 1 and `addr_valid` is 0.
- R9: In DONE, `step_req` and `escape_req` have no effect. `addr`, `end_cause` and `scan_done` hold, and `sweep_end` stays 0, until the next `cfg_load`.
- R10: A full scan yields the nested-loop sequence defined by R3 to R8, for raster, sheared, reversed-step and shrinking-origin programs.
- R11: Before the first `cfg_load` (IDLE), step and escape requests have no effect and `addr_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Capture configuration and start a new scan |
| cfg_base | input | 16 | Initial sweep origin (signed) |
| cfg_limit | input | 16 | Initial sweep bound (signed) |
| cfg_base_delta | input | 16 | Origin movement per sweep (signed) |
| cfg_limit_delta | input | 16 | Bound movement per sweep (signed) |
| cfg_addr_step | input | 16 | Address step within a sweep (signed) |
| cfg_outer_limit | input | 16 | Outer bound for the origin (signed) |
| cfg_max_steps | input | 16 | Maximum number of addresses per sweep; 0 means no limit |
| step_req | input | 1 | Request the next address |
| escape_req | input | 1 | End the current sweep immediately |
| addr | output | 16 | Current address |
| addr_valid | output | 1 | Unit is sweeping and `addr` is in use |
| sweep_end | output | 1 | One-cycle pulse after a sweep ends |
| scan_done | output | 1 | Whole scan finished |
| end_cause | output | 2 | Last end cause: 00 none, 01 escape, 10 bound, 11 count |

## Verification
The embedded assertions check the following on every cycle:
- an ordinary step moves `addr` by exactly the programmed step;
- the per-sweep counter stays below a non-zero maximum;
- each `sweep_end` carries a non-zero cause and leaves `addr` equal to the moved origin;
- DONE is sticky and freezes `addr`;
- `addr_valid` and `scan_done` are never both set;
- a load always clears the status outputs.

Only the bench scenarios can show that full address sequences match the intended scan shapes. They also show:
- the priority among simultaneous end causes;
- the direction-dependent "past the outer bound" rule for negative origin deltas;
- that requests are ignored before the first load.

// File: rtl/sau_pkg.sv
package sau_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_DONE  = 2'd2
    } sau_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_ESC   = 2'b01,
        CAUSE_LIMIT = 2'b10,
        CAUSE_COUNT = 2'b11
    } sau_cause_t;

    localparam int N_CELLS   = 3;
    localparam int CELL_BASE = 0;
    localparam int CELL_LIM  = 1;
    localparam int CELL_ADDR = 2;

endpackage

// File: rtl/sau_stepper_cell.sv
module sau_stepper_cell #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic signed [W-1:0] load_val,
    input  logic                adv_en,
    input  logic signed [W-1:0] delta,
    output logic signed [W-1:0] value,
    output logic signed [W-1:0] value_next
);

    assign value_next = value + delta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load_en) begin
            value <= load_val;
        end else if (adv_en) begin
            value <= value_next;
        end
    end

    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !adv_en) |=> $stable(value)); // R7

endmodule

// File: rtl/sau_step_counter.sv
module sau_step_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] max_steps,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (max_steps != '0) |-> (cnt < max_steps)); // R5

endmodule

// File: rtl/sau_end_detect.sv
module sau_end_detect #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic                 active,
    input  logic                 step_req,
    input  logic                 escape_req,
    input  logic signed [AW-1:0] addr,
    input  logic signed [AW-1:0] limit,
    input  logic        [CW-1:0] cnt,
    input  logic        [CW-1:0] max_steps,
    input  logic signed [AW-1:0] base_next,
    input  logic signed [AW-1:0] base_delta,
    input  logic signed [AW-1:0] outer_limit,
    output logic                 sweep_fin,
    output logic                 scan_fin,
    output logic                 step_take,
    output sau_pkg::sau_cause_t  cause
);
    import sau_pkg::*;

    logic        hit_limit;
    logic        hit_count;
    logic        passed;
    logic [CW:0] cnt_plus;

    always_comb begin
        cnt_plus  = {1'b0, cnt} + 1'b1;
        hit_limit = (addr == limit);
        hit_count = (max_steps != '0) && (cnt_plus == {1'b0, max_steps});
        cause     = CAUSE_NONE;
        sweep_fin = 1'b0;
        step_take = 1'b0;
        if (active) begin
            if (escape_req) begin
                cause     = CAUSE_ESC;
                sweep_fin = 1'b1;
            end else if (step_req && hit_limit) begin
                cause     = CAUSE_LIMIT;
                sweep_fin = 1'b1;
            end else if (step_req && hit_count) begin
                cause     = CAUSE_COUNT;
                sweep_fin = 1'b1;
            end else if (step_req) begin
                step_take = 1'b1;
            end
        end
        passed   = base_delta[AW-1] ? (base_next < outer_limit) : (base_next > outer_limit);
        scan_fin = sweep_fin && passed;
    end

endmodule

// File: rtl/sau_ctrl.sv
module sau_ctrl (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic                sweep_fin,
    input  logic                scan_fin,
    input  sau_pkg::sau_cause_t cause_in,
    output sau_pkg::sau_state_t state,
    output logic                addr_valid,
    output logic                scan_done,
    output logic                sweep_end,
    output logic [1:0]          end_cause
);
    import sau_pkg::*;

    sau_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cfg_load) state_nx = ST_SWEEP;
            ST_SWEEP: begin
                if (cfg_load)      state_nx = ST_SWEEP;
                else if (scan_fin) state_nx = ST_DONE;
            end
            ST_DONE:  if (cfg_load) state_nx = ST_SWEEP;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            scan_done  <= 1'b0;
            sweep_end  <= 1'b0;
            end_cause  <= CAUSE_NONE;
        end else begin
            addr_valid <= (state_nx == ST_SWEEP);
            scan_done  <= (state_nx == ST_DONE);
            sweep_end  <= sweep_fin && !cfg_load;
            if (cfg_load)       end_cause <= CAUSE_NONE;
            else if (sweep_fin) end_cause <= cause_in;
        end
    end

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (addr_valid && !scan_done && !sweep_end && end_cause == 2'b00)); // R2
    AST_CAUSE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_end |-> (end_cause != 2'b00)); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && !cfg_load) |=> (scan_done && !sweep_end && $stable(end_cause))); // R9
    AST_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && scan_done)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cfg_load) |=> !addr_valid); // R11

endmodule

// File: rtl/slide_addr_unit.sv
module slide_addr_unit #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic signed [AW-1:0] cfg_base,
    input  logic signed [AW-1:0] cfg_limit,
    input  logic signed [AW-1:0] cfg_base_delta,
    input  logic signed [AW-1:0] cfg_limit_delta,
    input  logic signed [AW-1:0] cfg_addr_step,
    input  logic signed [AW-1:0] cfg_outer_limit,
    input  logic        [CW-1:0] cfg_max_steps,
    input  logic                 step_req,
    input  logic                 escape_req,
    output logic signed [AW-1:0] addr,
    output logic                 addr_valid,
    output logic                 sweep_end,
    output logic                 scan_done,
    output logic        [1:0]    end_cause
);
    import sau_pkg::*;

    logic signed [AW-1:0] base_delta_q, limit_delta_q, addr_step_q, outer_q;
    logic        [CW-1:0] max_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_delta_q  <= '0;
            limit_delta_q <= '0;
            addr_step_q   <= '0;
            outer_q       <= '0;
            max_q         <= '0;
        end else if (cfg_load) begin
            base_delta_q  <= cfg_base_delta;
            limit_delta_q <= cfg_limit_delta;
            addr_step_q   <= cfg_addr_step;
            outer_q       <= cfg_outer_limit;
            max_q         <= cfg_max_steps;
        end
    end

    sau_state_t           state;
    sau_cause_t           cause;
    logic                 sweep_fin, scan_fin, step_take;
    logic        [CW-1:0] cnt;

    logic                 cell_load  [N_CELLS];
    logic                 cell_adv   [N_CELLS];
    logic signed [AW-1:0] cell_lval  [N_CELLS];
    logic signed [AW-1:0] cell_delta [N_CELLS];
    logic signed [AW-1:0] cell_value [N_CELLS];
    logic signed [AW-1:0] cell_next  [N_CELLS];

    always_comb begin
        cell_load[CELL_BASE]  = cfg_load;
        cell_adv[CELL_BASE]   = sweep_fin;
        cell_lval[CELL_BASE]  = cfg_base;
        cell_delta[CELL_BASE] = base_delta_q;

        cell_load[CELL_LIM]   = cfg_load;
        cell_adv[CELL_LIM]    = sweep_fin;
        cell_lval[CELL_LIM]   = cfg_limit;
        cell_delta[CELL_LIM]  = limit_delta_q;

        cell_load[CELL_ADDR]  = cfg_load || sweep_fin;
        cell_adv[CELL_ADDR]   = step_take;
        cell_lval[CELL_ADDR]  = cfg_load ? cfg_base : cell_next[CELL_BASE];
        cell_delta[CELL_ADDR] = addr_step_q;
    end

    for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_cell
        sau_stepper_cell #(.W(AW)) i_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_en    (cell_load[gi]),
            .load_val   (cell_lval[gi]),
            .adv_en     (cell_adv[gi]),
            .delta      (cell_delta[gi]),
            .value      (cell_value[gi]),
            .value_next (cell_next[gi])
        );
    end

    sau_end_detect #(.AW(AW), .CW(CW)) i_end (
        .active      ((state == ST_SWEEP) && !cfg_load),
        .step_req    (step_req),
        .escape_req  (escape_req),
        .addr        (cell_value[CELL_ADDR]),
        .limit       (cell_value[CELL_LIM]),
        .cnt         (cnt),
        .max_steps   (max_q),
        .base_next   (cell_next[CELL_BASE]),
        .base_delta  (base_delta_q),
        .outer_limit (outer_q),
        .sweep_fin   (sweep_fin),
        .scan_fin    (scan_fin),
        .step_take   (step_take),
        .cause       (cause)
    );

    sau_step_counter #(.CW(CW)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cfg_load || sweep_fin),
        .inc       (step_take),
        .max_steps (max_q),
        .cnt       (cnt)
    );

    sau_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .sweep_fin  (sweep_fin),
        .scan_fin   (scan_fin),
        .cause_in   (cause),
        .state      (state),
        .addr_valid (addr_valid),
        .scan_done  (scan_done),
        .sweep_end  (sweep_end),
        .end_cause  (end_cause)
    );

    assign addr = cell_value[CELL_ADDR];

    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && step_req && !escape_req && !cfg_load && !sweep_fin)
        |=> (addr == $past(addr + addr_step_q))); // R3
    AST_RESTART_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_end |-> (addr == cell_value[CELL_BASE])); // R7
    AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && !cfg_load) |=> $stable(addr)); // R9

endmodule

// File: tb/test_slide_addr_unit.sv
module test_slide_addr_unit;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_load = 1'b0;
    logic signed [15:0] cfg_base = '0, cfg_limit = '0, cfg_base_delta = '0;
    logic signed [15:0] cfg_limit_delta = '0, cfg_addr_step = '0, cfg_outer_limit = '0;
    logic        [15:0] cfg_max_steps = '0;
    logic               step_req = 1'b0, escape_req = 1'b0;
    logic signed [15:0] addr;
    logic               addr_valid, sweep_end, scan_done;
    logic        [1:0]  end_cause;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    slide_addr_unit i_slide_addr_unit (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .cfg_base_delta(cfg_base_delta), .cfg_limit_delta(cfg_limit_delta),
        .cfg_addr_step(cfg_addr_step), .cfg_outer_limit(cfg_outer_limit),
        .cfg_max_steps(cfg_max_steps), .step_req(step_req), .escape_req(escape_req),
        .addr(addr), .addr_valid(addr_valid), .sweep_end(sweep_end),
        .scan_done(scan_done), .end_cause(end_cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic s, input logic e);
        step_req   = s;
        escape_req = e;
        @(posedge clk);
        #1;
        step_req   = 1'b0;
        escape_req = 1'b0;
    endtask

    task automatic load(input logic signed [15:0] b, l, bd, ld, st, outer,
                        input logic [15:0] mx, input logic s, input logic e);
        cfg_base = b; cfg_limit = l; cfg_base_delta = bd; cfg_limit_delta = ld;
        cfg_addr_step = st; cfg_outer_limit = outer; cfg_max_steps = mx;
        cfg_load = 1'b1;
        step_req = s; escape_req = e;
        @(posedge clk);
        #1;
        cfg_load = 1'b0; step_req = 1'b0; escape_req = 1'b0;
        chk("R2 addr after load", addr, b);
        chk("R2 valid after load", addr_valid, 1);
        chk("R2 cause cleared", end_cause, 0);
        chk("R2 done cleared", scan_done, 0);
    endtask

    // Run a whole scan against an independent model of R3..R8.
    task automatic run_scan(input string name, input logic signed [15:0] b0, l0, bd, ld,
                            input logic signed [15:0] st, outer, input logic [15:0] mx);
        logic signed [15:0] b, l, a;
        int cnt;
        logic fin, done;
        logic [1:0] cz;
        load(b0, l0, bd, ld, st, outer, mx, 1'b0, 1'b0);
        b = b0; l = l0; a = b0; cnt = 0; done = 1'b0;
        for (int i = 0; i < 400 && !done; i++) begin
            fin = 1'b1;
            if (a == l) cz = 2'b10;
            else if (mx != 0 && cnt + 1 == int'(mx)) cz = 2'b11;
            else begin fin = 1'b0; cz = 2'b00; end
            tick(1'b1, 1'b0);
            if (fin) begin
                b = b + bd; l = l + ld; a = b; cnt = 0;
                done = bd[15] ? (b < outer) : (b > outer);
                chk({name, " R7 sweep_end"}, sweep_end, 1);
                chk({name, " R4/R5 cause"}, end_cause, cz);
                chk({name, " R8 done"}, scan_done, done);
                chk({name, " R8 valid"}, addr_valid, !done);
                if (!done) chk({name, " R7 restart addr"}, addr, a);
            end else begin
                a = a + st; cnt++;
                chk({name, " R3 step addr"}, addr, a);
                chk({name, " R10 no end"}, sweep_end, 0);
            end
        end
        chk({name, " R10 scan finished"}, scan_done, 1);
    endtask

    task automatic t_reset();
        chk("R1 addr", addr, 0);
        chk("R1 valid", addr_valid, 0);
        chk("R1 done", scan_done, 0);
        chk("R1 sweep_end", sweep_end, 0);
        chk("R1 cause", end_cause, 0);
    endtask

    task automatic t_idle();
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b1);
        chk("R11 idle valid", addr_valid, 0);
        chk("R11 idle addr", addr, 0);
        chk("R11 idle sweep_end", sweep_end, 0);
    endtask

    task automatic t_done_ignores();
        logic signed [15:0] a0;
        logic [1:0] c0;
        a0 = addr; c0 = end_cause;
        for (int i = 0; i < 3; i++) begin
            tick(1'b1, i[0]);
            chk("R9 addr held", addr, a0);
            chk("R9 done held", scan_done, 1);
            chk("R9 cause held", end_cause, c0);
            chk("R9 no sweep_end", sweep_end, 0);
            chk("R9 valid low", addr_valid, 0);
        end
    endtask

    task automatic t_escape();
        load(16'sd0, 16'sd100, 16'sd10, 16'sd10, 16'sd1, 16'sd1000, 16'd0, 1'b0, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        chk("R3 addr before escape", addr, 2);
        tick(1'b0, 1'b1);
        chk("R6 escape sweep_end", sweep_end, 1);
        chk("R6 escape cause", end_cause, 2'b01);
        chk("R7 addr at new origin", addr, 10);
        tick(1'b0, 1'b0);
        chk("R7 sweep_end one cycle", sweep_end, 0);
        // bound and count both true: escape wins, then bound wins over count
        load(16'sd0, 16'sd0, 16'sd5, 16'sd5, 16'sd1, 16'sd100, 16'd1, 1'b0, 1'b0);
        tick(1'b1, 1'b1);
        chk("R6 escape beats bound", end_cause, 2'b01);
        chk("R6 addr after escape", addr, 5);
        tick(1'b1, 1'b0);
        chk("R6 bound beats count", end_cause, 2'b10);
    endtask

    task automatic t_load_priority();
        load(16'sd7, 16'sd9, 16'sd1, 16'sd1, 16'sd1, 16'sd50, 16'd0, 1'b0, 1'b0);
        tick(1'b1, 1'b0);
        load(16'sd30, 16'sd40, 16'sd1, 16'sd1, 16'sd1, 16'sd50, 16'd0, 1'b1, 1'b1);
        chk("R2 load beats requests sweep_end", sweep_end, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_idle();
        run_scan("raster", 16'sd0, 16'sd3, 16'sd16, 16'sd16, 16'sd1, 16'sd48, 16'd0);
        t_done_ignores();
        run_scan("shear", 16'sd100, 16'sd9999, 16'sd17, 16'sd0, 16'sd1, 16'sd134, 16'd3);
        run_scan("reverse", 16'sd40, 16'sd10, 16'sd1, 16'sd1, -16'sd10, 16'sd42, 16'd0);
        run_scan("shrink", 16'sd5, 16'sd6, -16'sd2, -16'sd2, 16'sd1, 16'sd1, 16'd0);
        run_scan("trapezoid", 16'sd0, 16'sd4, 16'sd9, 16'sd10, 16'sd1, 16'sd30, 16'd0);
        t_done_ignores();
        t_escape();
        t_load_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule